// File: doc/BRIEF.md
# Serial ADC Read Controller

This block runs single read transactions against an 8-bit serial analog-to-digital converter that takes a 4-bit channel address. A host raises `start` for one cycle with a channel number. The controller pulls the active-low select low and waits a settling interval. It then produces eight I/O clock pulses. During the first four it sends the channel address, most significant bit first. Across all eight it assembles the byte the converter returns.

The converter always returns the result of the conversion that the previous frame requested. The first byte after power-up is whatever the converter held before, and each later byte belongs to the channel sent one frame earlier. A host that wants channel N therefore issues two frames and keeps the second byte. Once the eighth falling clock edge starts a conversion, the controller raises select and stays busy for a fixed conversion wait. Only after that wait does it accept a new request.

The I/O clock half-period, the select-to-first-edge settling time and the conversion wait are all counted in host clock cycles and set by parameters.

Top module: `sadc_read_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `cs_n`=1, `sclk`=0, `busy`=0, `result_valid`=0 and `result`=0.
- R2: A `start` seen on a clock edge while idle pulls `cs_n` low and raises `busy` on that same edge. The first rising edge of `sclk` follows exactly SETUP_CYC host cycles after `cs_n` falls.
- R3: At each of the first four rising edges of `sclk` in a frame, `sdo` carries channel bits 3, 2, 1 and 0 in that order, and it does not change on any rising edge.
- R4: A frame has exactly eight `sclk` pulses. The high and low halves each last HALF_CYC host cycles, and `cs_n` returns high on the same edge as the eighth falling edge of `sclk`.
- R5: `sclk` is low whenever `cs_n` is high.
- R6: `result` holds the byte read on `sdi`. Bit 7 is the level on `sdi` at the first rising edge of `sclk`, and bits 6 down to 0 are the levels at rising edges 2 through 8. `result_valid` is high for exactly one cycle per frame, at the eighth falling edge, and `result` holds its value until the next frame.
- R7: A `start` that arrives while `busy` is high starts no frame and does not change the channel of the frame in progress.
- R8: `busy` falls exactly CONV_CYC host cycles after `cs_n` rises, so the next falling edge of `cs_n` comes at least CONV_CYC+1 cycles after the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run a frame |
| channel | input | 4 | Channel address for the requested frame |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Converter I/O clock, idles low |
| sdo | output | 1 | Serial channel address to the converter |
| sdi | input | 1 | Serial result data from the converter |
| result | output | 8 | Last captured byte |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |
| busy | output | 1 | High from an accepted start until the conversion wait ends |

## Verification
The bench has its own converter model, and each fault in the sequencer or the shift logic shows up at the ports within the frame that contains it. If the fall counter is off, the model counts seven or nine clock pulses when select rises. If the address register is off, the model decodes the wrong channel on the fourth rising edge. If a capture lands in the wrong slot, the scoreboard sees a byte with swapped or shifted bits at that frame's `result_valid`. If a timer load value is wrong, the half-period, settling or conversion-wait timing moves by whole host cycles, and the bench measures that interval to the cycle.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_CLOCK = 2'd2,
    ST_CONV  = 2'd3
  } sadc_state_t;

  // Timer reload value for an interval of n cycles (minimum one cycle).
  function automatic int unsigned interval_load(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  // Bits needed to hold any value up to and including n.
  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Largest of three interval parameters.
  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sadc_timer.sv
module sadc_timer #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // R4: the interval counter only ever steps down by one between loads
  a_r4_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $past(cnt) != '0) |-> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sadc_shift.sv
module sadc_shift #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_addr,
  input  logic [AW-1:0] addr_in,
  input  logic          shift_addr,
  input  logic          cap,
  input  logic          sdi,
  output logic          sdo,
  output logic [DW-1:0] data
);

  logic [AW-1:0] addr_sr;

  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return {a[AW-2:0], 1'b0};
  endfunction

  function automatic logic [DW-1:0] data_step(input logic [DW-1:0] d, input logic b);
    return {d[DW-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_sr <= '0;
    end else if (load_addr) begin
      addr_sr <= addr_in;
    end else if (shift_addr) begin
      addr_sr <= addr_step(addr_sr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
    end else if (cap) begin
      data <= data_step(data, sdi);
    end
  end

  assign sdo = addr_sr[AW-1];

  // R3: a new address is never loaded in the same cycle as a shift
  a_r3_load_or_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_addr && shift_addr));

endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned CW        = 6,
  parameter int unsigned HALF_CYC  = 3,
  parameter int unsigned SETUP_CYC = 4,
  parameter int unsigned CONV_CYC  = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          load_addr,
  output logic          shift_addr,
  output logic          cap,
  output logic          fire,
  output logic          cs_n,
  output logic          sclk,
  output logic          busy,
  output logic          result_valid
);

  localparam int unsigned FW = bits_for(DW - 1);
  localparam logic [CW-1:0] LD_SETUP = CW'(interval_load(SETUP_CYC));
  localparam logic [CW-1:0] LD_HALF  = CW'(interval_load(HALF_CYC));
  localparam logic [CW-1:0] LD_CONV  = CW'(interval_load(CONV_CYC));
  localparam logic [FW-1:0] LAST_FALL = FW'(DW - 1);

  sadc_state_t   st;
  logic [FW-1:0] falls;
  logic          cs_q, sclk_q, busy_q, vld_q;

  // Named internal events
  logic accept;      // start taken while idle
  logic setup_done;  // settling over, first rising edge now
  logic ev_rise;     // a later rising edge of sclk
  logic ev_fall;     // a falling edge of sclk
  logic last_fall;   // the eighth falling edge
  logic conv_done;   // conversion wait finished

  assign accept     = (st == ST_IDLE) && start;
  assign setup_done = (st == ST_SETUP) && expired;
  assign ev_fall    = (st == ST_CLOCK) && expired && sclk_q;
  assign ev_rise    = (st == ST_CLOCK) && expired && !sclk_q;
  assign last_fall  = ev_fall && (falls == LAST_FALL);
  assign conv_done  = (st == ST_CONV) && expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      falls  <= '0;
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            st     <= ST_SETUP;
            cs_q   <= 1'b0;
            busy_q <= 1'b1;
            falls  <= '0;
          end
        end
        ST_SETUP: begin
          if (setup_done) begin
            st     <= ST_CLOCK;
            sclk_q <= 1'b1;
          end
        end
        ST_CLOCK: begin
          if (ev_fall) begin
            sclk_q <= 1'b0;
            if (last_fall) begin
              st    <= ST_CONV;
              cs_q  <= 1'b1;
              vld_q <= 1'b1;
            end else begin
              falls <= falls + 1'b1;
            end
          end else if (ev_rise) begin
            sclk_q <= 1'b1;
          end
        end
        ST_CONV: begin
          if (conv_done) begin
            st     <= ST_IDLE;
            busy_q <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = LD_SETUP;
    end else if (last_fall) begin
      tmr_load = 1'b1;
      tmr_val  = LD_CONV;
    end else if (setup_done || ev_rise || ev_fall) begin
      tmr_load = 1'b1;
      tmr_val  = LD_HALF;
    end
  end

  assign load_addr    = accept;
  assign shift_addr   = ev_fall && !last_fall;
  assign cap          = setup_done || ev_rise;
  assign fire         = last_fall;
  assign cs_n         = cs_q;
  assign sclk         = sclk_q;
  assign busy         = busy_q;
  assign result_valid = vld_q;

  // R7: a request during a frame never restarts the select
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> !$fell(cs_q));

  // R4: select rises only together with a falling I/O clock edge
  a_r4_cs_with_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> $past(sclk_q));

  // R8: busy ends only while select is inactive
  a_r8_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> cs_q);

  // R2: select falls only as a frame begins
  a_r2_cs_fall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> (busy_q && !$past(busy_q)));

endmodule

// File: rtl/sadc_read_ctrl.sv
module sadc_read_ctrl
  import sadc_pkg::*;
#(
  parameter int unsigned AW        = 4,
  parameter int unsigned DW        = 8,
  parameter int unsigned HALF_CYC  = 3,
  parameter int unsigned SETUP_CYC = 4,
  parameter int unsigned CONV_CYC  = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] channel,
  output logic          cs_n,
  output logic          sclk,
  output logic          sdo,
  input  logic          sdi,
  output logic [DW-1:0] result,
  output logic          result_valid,
  output logic          busy
);

  localparam int unsigned CW = bits_for(max3(HALF_CYC, SETUP_CYC, CONV_CYC));

  logic          tmr_load, expired;
  logic [CW-1:0] tmr_val;
  logic          load_addr, shift_addr, cap, fire;
  logic [DW-1:0] data;

  sadc_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  sadc_seq #(
    .DW        (DW),
    .CW        (CW),
    .HALF_CYC  (HALF_CYC),
    .SETUP_CYC (SETUP_CYC),
    .CONV_CYC  (CONV_CYC)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .expired      (expired),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .load_addr    (load_addr),
    .shift_addr   (shift_addr),
    .cap          (cap),
    .fire         (fire),
    .cs_n         (cs_n),
    .sclk         (sclk),
    .busy         (busy),
    .result_valid (result_valid)
  );

  sadc_shift #(.AW(AW), .DW(DW)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_addr  (load_addr),
    .addr_in    (channel),
    .shift_addr (shift_addr),
    .cap        (cap),
    .sdi        (sdi),
    .sdo        (sdo),
    .data       (data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
    end else if (fire) begin
      result <= data;
    end
  end

  // R5: the I/O clock is never high with select inactive
  a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R3: the address line never moves on a rising I/O clock edge
  a_r3_sdo_stable_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdo));

  // R6: the valid strobe lasts one cycle
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R6: the result only changes with its strobe
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result));

endmodule

// File: tb/sim_sadc_read_ctrl.sv
module sim_sadc_read_ctrl;

  localparam int CLK_P = 10;
  localparam int HALF  = 3;
  localparam int SETUP = 4;
  localparam int CONV  = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] channel = '0;
  logic       cs_n, sclk, sdo, result_valid, busy;
  logic       sdi = 1'b0;
  logic [7:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  sadc_read_ctrl #(
    .AW(4), .DW(8), .HALF_CYC(HALF), .SETUP_CYC(SETUP), .CONV_CYC(CONV)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .channel(channel),
    .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .sdi(sdi),
    .result(result), .result_valid(result_valid), .busy(busy)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Converter's result for a channel, as modelled by the bench
  function automatic logic [7:0] conv_of(input logic [3:0] ch);
    return (8'(ch) * 8'd29) ^ 8'h6C;
  endfunction

  logic [7:0] exp_q[$];
  logic [3:0] addr_q[$];
  logic [7:0] exp_prev = 8'hA5;
  logic [7:0] last_seen = 8'h00;

  // Converter model
  logic [7:0] adc_prev = 8'hA5;
  logic [3:0] addr_got;
  int  rises, falls, frames = 0, r5_viol = 0;
  bit  in_frame = 1'b0;
  longint t_csf = 0, t_last = 0, t_csr = 0;

  always @(negedge cs_n) if (rst_n) begin
    if (frames > 0)
      chk(($time - t_csr) >= (CONV + 1) * CLK_P, "R8 gap", $time - t_csr, (CONV + 1) * CLK_P);
    frames++;
    in_frame = 1'b1;
    rises = 0;
    falls = 0;
    addr_got = '0;
    sdi = adc_prev[7];
    t_csf = $time;
    t_last = $time;
  end

  always @(posedge sclk) if (rst_n) begin
    rises++;
    if (rises == 1)
      chk(($time - t_csf) == SETUP * CLK_P, "R2 setup", $time - t_csf, SETUP * CLK_P);
    else
      chk(($time - t_last) == HALF * CLK_P, "R4 low half", $time - t_last, HALF * CLK_P);
    t_last = $time;
    if (rises <= 4) addr_got = {addr_got[2:0], sdo};
  end

  always @(negedge sclk) if (rst_n) begin
    falls++;
    chk(($time - t_last) == HALF * CLK_P, "R4 high half", $time - t_last, HALF * CLK_P);
    t_last = $time;
    if (falls < 8) sdi = adc_prev[7 - falls];
    else adc_prev = conv_of(addr_got);
  end

  always @(posedge cs_n) if (rst_n && in_frame) begin
    t_csr = $time;
    in_frame = 1'b0;
    #1;
    chk(falls == 8, "R4 falls", falls, 8);
    chk(rises == 8, "R4 rises", rises, 8);
    if (addr_q.size() == 0) chk(1'b0, "R3 extra frame", 1, 0);
    else begin
      logic [3:0] e;
      e = addr_q.pop_front();
      chk(addr_got == e, "R3 address", addr_got, e);
    end
  end

  always @(negedge busy) if (rst_n)
    chk(($time - t_csr) == CONV * CLK_P, "R8 wait", $time - t_csr, CONV * CLK_P);

  // Scoreboard monitor
  logic prev_vld = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (cs_n && sclk) r5_viol++;
    if (result_valid) begin
      chk(!prev_vld, "R6 pulse", prev_vld, 0);
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected", result, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(result == e, "R6 byte", result, e);
        last_seen = e;
      end
    end
    prev_vld = result_valid;
  end

  task automatic do_frame(input logic [3:0] ch);
    @(negedge clk);
    while (busy) @(negedge clk);
    exp_q.push_back(exp_prev);
    exp_prev = conv_of(ch);
    addr_q.push_back(ch);
    channel = ch;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!cs_n && busy, "R2 accept", {cs_n, busy}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1 pins", {cs_n, sclk}, 2'b10);
    chk(!busy && !result_valid && result == 8'h00, "R1 outputs", {busy, result_valid, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && !busy && result == 8'h00, "R1 after release", {cs_n, sclk, busy}, 3'b100);

    do_frame(4'h0);
    do_frame(4'hF);
    do_frame(4'h5);
    do_frame(4'hA);
    do_frame(4'h9);
    // R7: request mid-frame with another channel must be dropped
    repeat (10) @(negedge clk);
    channel = 4'h3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    channel = 4'h0;
    do_frame(4'h6);
    do_frame(4'h0);
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);

    chk(frames == 7, "R7 frame count", frames, 7);
    chk(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);
    chk(result == last_seen, "R6 result held", result, last_seen);
    chk(r5_viol == 0, "R5 sclk low when idle", r5_viol, 0);
    chk(cs_n && !sclk, "R5 idle pins", {cs_n, sclk}, 2'b10);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule